// File: doc/BRIEF.md
# Serial Port Interrupt Gate and Priority Encoder

This block decides whether a 16550-style serial port is asking the host for attention, and for which reason. Four kinds of condition arrive from the rest of the port: a receive error (overrun, parity, framing or break), received data waiting or a character timeout, the transmit holding register running empty, and a change on a modem control line. The block latches the event-type conditions and masks every source with a 4-bit enable register. It drives one interrupt line and presents an identification code that names the most urgent enabled source.

The host reaches two registers through a small synchronous bus. One is the enable register (read/write). The other is the identification register (read-only). Reading the identification register can itself acknowledge a transmitter-empty interrupt. Reads of the line and modem status registers, and writes to the transmit holding register, belong to other logic. They reach this block only as one-cycle strobes.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, the enable register reads 0x00, no source is pending, the identification register reads 0x01 and `irq` is low.
- R2: A write at `addr` = 1 stores `wrData[3:0]` in the enable register, and the new value acts from the next cycle. Reading address 1 returns the stored bits in [3:0], with bits 7:4 always zero.
- R3: The identification register (`addr` = 2) reads 0x06 for a line-status error. Otherwise it reads 0x0C for a timeout or 0x04 for data available, then 0x02 for transmitter empty, then 0x00 for a modem change. It reads 0x01 when no enabled source is pending. Checks go in that priority order.
- R4: `irq` is high exactly when bit 0 of the identification register is zero.
- R5: Enable bit 0 gates both receive sources. `rxTimeout` counts only while `fifoMode` is high, and then takes code 0x0C in place of 0x04. Both receive inputs are levels that act in the same cycle.
- R6: Enable bit 2 gates the line-status source. A pulse on `lsErr` latches it, and an `lsrRd` strobe clears it.
- R7: Enable bit 3 gates the modem source. A pulse on `msChg` latches it, and an `msrRd` strobe clears it.
- R8: Enable bit 1 gates the transmitter-empty source. A pulse on `thrEmpty` latches it. A `thrWr` strobe clears it. A read with `rdEn` of the identification register clears it only while the register shows 0x02.
- R9: When a set pulse and a clear strobe for the same latched source fall in the same cycle, the source stays pending.
- R10: Sources latch even while their enable is low. Setting the enable later exposes them without a new event, and with all enables low `irq` stays low.
- R11: `rdData` follows `addr` combinationally. Addresses other than 1 and 2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; triggers read side effects |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| lsErr | input | 1 | Pulse: receive error detected |
| rxAvail | input | 1 | Level: received data available |
| rxTimeout | input | 1 | Level: character timeout |
| fifoMode | input | 1 | Level: FIFOs enabled |
| thrEmpty | input | 1 | Pulse: transmit holding register became empty |
| msChg | input | 1 | Pulse: a modem line changed |
| lsrRd | input | 1 | Strobe: line status register read |
| msrRd | input | 1 | Strobe: modem status register read |
| thrWr | input | 1 | Strobe: transmit holding register written |
| irq | output | 1 | Interrupt request |

## Verification
The receive levels reach `irq` and the identification code in the same cycle. Enable writes, latched events and every clear strobe show their effect one clock edge after they are applied. The bench drives all inputs on the falling edge and reads results on the falling edge after the capturing rising edge, so each latched result is sampled exactly one edge after its stimulus. It peeks at the identification register with `rdEn` low, so the peek cannot acknowledge anything. Side-effecting reads are issued only where a clear is under test.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int EN_W = 4;

  // enable bit positions
  localparam int EN_RX  = 0;
  localparam int EN_THR = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MS  = 3;

  // identification codes (bit 0 high means nothing pending)
  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_RX   = 4'b0100;
  localparam logic [3:0] ID_THR  = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;

  typedef struct packed {
    logic enWr;
    logic thrClr;
    logic lsClr;
    logic msClr;
  } irqStrb_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int EN_ADDR = 1,
  parameter int ID_ADDR = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsrRd,
  input  logic              msrRd,
  input  logic              thrWr,
  input  logic              thrShown,
  output irqStrb_t          strb
);

  logic enSel;
  logic idSel;

  assign enSel = (addr == ADDR_W'(EN_ADDR));
  assign idSel = (addr == ADDR_W'(ID_ADDR));

  always_comb begin
    strb        = '0;
    strb.enWr   = wrEn && enSel;
    // acknowledge transmitter-empty only when the id read shows it
    strb.thrClr = thrWr || (rdEn && idSel && thrShown);
    strb.lsClr  = lsrRd;
    strb.msClr  = msrRd;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  irqStrb_t        strb,
  input  logic [EN_W-1:0] enData,
  input  logic            lsErr,
  input  logic            rxAvail,
  input  logic            rxTimeout,
  input  logic            fifoMode,
  input  logic            thrEmpty,
  input  logic            msChg,
  output logic [EN_W-1:0] enReg,
  output logic [3:0]      idCode,
  output logic            irq,
  output logic            thrShown
);

  logic lsPend;
  logic msPend;
  logic thrPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      lsPend  <= 1'b0;
      msPend  <= 1'b0;
      thrPend <= 1'b0;
    end else begin
      if (strb.enWr) enReg <= enData;
      // a set in the same cycle as a clear wins
      if (lsErr)           lsPend  <= 1'b1;
      else if (strb.lsClr) lsPend  <= 1'b0;
      if (msChg)           msPend  <= 1'b1;
      else if (strb.msClr) msPend  <= 1'b0;
      if (thrEmpty)         thrPend <= 1'b1;
      else if (strb.thrClr) thrPend <= 1'b0;
    end
  end

  always_comb begin
    if (enReg[EN_LS] && lsPend)                       idCode = ID_LS;
    else if (enReg[EN_RX] && fifoMode && rxTimeout)   idCode = ID_TMO;
    else if (enReg[EN_RX] && rxAvail)                 idCode = ID_RX;
    else if (enReg[EN_THR] && thrPend)                idCode = ID_THR;
    else if (enReg[EN_MS] && msPend)                  idCode = ID_MS;
    else                                              idCode = ID_NONE;
  end

  assign irq      = !idCode[0];
  assign thrShown = (idCode == ID_THR);

  p_ls_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    lsErr |=> lsPend);
  p_ls_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lsClr && !lsErr) |=> !lsPend);
  p_ms_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.msClr && !msChg) |=> !msPend);
  p_thr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.thrClr && !thrEmpty) |=> !thrPend);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (thrEmpty && strb.thrClr) |=> thrPend);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irq);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int EN_ADDR = 1,
  parameter int ID_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              lsErr,
  input  logic              rxAvail,
  input  logic              rxTimeout,
  input  logic              fifoMode,
  input  logic              thrEmpty,
  input  logic              msChg,
  input  logic              lsrRd,
  input  logic              msrRd,
  input  logic              thrWr,
  output logic              irq
);

  irqStrb_t        strb;
  logic [EN_W-1:0] enReg;
  logic [3:0]      idCode;
  logic            thrShown;
  logic            unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:EN_W];

  uart_irq_ctrl #(
    .ADDR_W (ADDR_W),
    .EN_ADDR(EN_ADDR),
    .ID_ADDR(ID_ADDR)
  ) uCtrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .lsrRd   (lsrRd),
    .msrRd   (msrRd),
    .thrWr   (thrWr),
    .thrShown(thrShown),
    .strb    (strb)
  );

  uart_irq_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .enData   (wrData[EN_W-1:0]),
    .lsErr    (lsErr),
    .rxAvail  (rxAvail),
    .rxTimeout(rxTimeout),
    .fifoMode (fifoMode),
    .thrEmpty (thrEmpty),
    .msChg    (msChg),
    .enReg    (enReg),
    .idCode   (idCode),
    .irq      (irq),
    .thrShown (thrShown)
  );

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(EN_ADDR))      rdData = DATA_W'(enReg);
    else if (addr == ADDR_W'(ID_ADDR)) rdData = DATA_W'(idCode);
  end

  p_en_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(EN_ADDR)) |-> (rdData[DATA_W-1:EN_W] == '0));
  p_id_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(ID_ADDR)) |-> (rdData[0] == !irq));

endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;

  logic       clk = 1'b0;
  logic       rstN, wrEn, rdEn, lsErr, rxAvail, rxTimeout, fifoMode;
  logic       thrEmpty, msChg, lsrRd, msrRd, thrWr, irq;
  logic [1:0] addr;
  logic [7:0] wrData, rdData;
  int         testCnt = 0;
  int         failCnt = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_prio u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .lsErr(lsErr), .rxAvail(rxAvail),
    .rxTimeout(rxTimeout), .fifoMode(fifoMode), .thrEmpty(thrEmpty),
    .msChg(msChg), .lsrRd(lsrRd), .msrRd(msrRd), .thrWr(thrWr), .irq(irq)
  );

  localparam logic [1:0] A_EN = 2'd1;
  localparam logic [1:0] A_ID = 2'd2;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expId(logic [3:0] e, logic ls, logic rxA,
      logic tmo, logic fm, logic thr, logic ms);
    if (e[2] && ls)              return 8'h06;
    else if (e[0] && fm && tmo)  return 8'h0C;
    else if (e[0] && rxA)        return 8'h04;
    else if (e[1] && thr)        return 8'h02;
    else if (e[3] && ms)         return 8'h00;
    else                         return 8'h01;
  endfunction

  task automatic quiet();
    wrEn = 0; rdEn = 0; lsErr = 0; thrEmpty = 0; msChg = 0;
    lsrRd = 0; msrRd = 0; thrWr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    quiet();
  endtask

  task automatic peekId(string req, logic [7:0] exp);
    addr = A_ID; #1;
    chk(req, rdData, exp);
    chk(req, {7'd0, irq}, {7'd0, exp != 8'h01});
  endtask

  task automatic writeEn(logic [7:0] d);
    wrEn = 1; addr = A_EN; wrData = d;
    step();
  endtask

  initial begin
    rstN = 0; addr = 0; wrData = 0; rxAvail = 0; rxTimeout = 0; fifoMode = 0;
    quiet();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    peekId("R1", 8'h01);
    addr = A_EN; #1; chk("R1", rdData, 8'h00);

    // R3 R4 R5 exhaustive sweep: enables x source patterns
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 64; p++) begin
        logic [5:0] pv;
        pv = 6'(p);
        wrEn = 1; addr = A_EN; wrData = 8'(e);
        lsrRd = 1; msrRd = 1; thrWr = 1;
        rxAvail = pv[1]; rxTimeout = pv[2]; fifoMode = pv[3];
        step();
        lsErr = pv[0]; thrEmpty = pv[4]; msChg = pv[5];
        step();
        peekId("R3 R5", expId(4'(e), pv[0], pv[1], pv[2], pv[3], pv[4], pv[5]));
      end
    end

    // clean state
    rxAvail = 0; rxTimeout = 0; fifoMode = 0;
    lsrRd = 1; msrRd = 1; thrWr = 1; writeEn(8'h00);
    @(negedge clk);

    // R2 upper bits read zero
    writeEn(8'hFF);
    addr = A_EN; #1; chk("R2", rdData, 8'h0F);
    writeEn(8'hA5);
    addr = A_EN; #1; chk("R2", rdData, 8'h05);

    // R10 latch while disabled, then enable
    writeEn(8'h00);
    lsErr = 1; msChg = 1; thrEmpty = 1; step();
    peekId("R10", 8'h01);
    writeEn(8'h04);
    peekId("R10", 8'h06);

    // R6 lsrRd clears line status, revealing lower sources
    writeEn(8'h0E);
    lsrRd = 1; step();
    peekId("R6", 8'h02);

    // R8 id read while another source shown leaves thr pending
    lsErr = 1; step();
    rdEn = 1; addr = A_ID; step();
    lsrRd = 1; step();
    peekId("R8", 8'h02);
    // R8 id read while thr shown clears it
    rdEn = 1; addr = A_ID; step();
    peekId("R8", 8'h00);

    // R7 msrRd clears modem
    msrRd = 1; step();
    peekId("R7", 8'h01);

    // R8 thrWr clears
    thrEmpty = 1; step();
    peekId("R8", 8'h02);
    thrWr = 1; step();
    peekId("R8", 8'h01);

    // R9 set wins over clear
    thrEmpty = 1; thrWr = 1; step();
    peekId("R9", 8'h02);
    lsErr = 1; lsrRd = 1; step();
    peekId("R9", 8'h06);
    lsrRd = 1; step();

    // R5 timeout ignored outside fifo mode
    writeEn(8'h01);
    rxTimeout = 1; fifoMode = 0; #1;
    peekId("R5", 8'h01);
    fifoMode = 1; #1;
    peekId("R5", 8'h0C);
    rxTimeout = 0; fifoMode = 0;

    // R11 unmapped addresses read zero
    addr = 2'd0; #1; chk("R11", rdData, 8'h00);
    addr = 2'd3; #1; chk("R11", rdData, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule